// File: doc/BRIEF.md
# Interrupt Pin Service and End-of-Interrupt Engine

This block sits between a set of interrupt input lines and the fabric that carries interrupt messages to the processors. It keeps one pending bit per pin. A scan walks the pins, and for each pin that is ready to deliver it emits one message: a 32-bit address and a 32-bit data word on a valid/ready port. Each pin's behaviour comes from a 64-bit redirection entry, supplied as a flat table input. That entry gives the vector, the delivery mode, the destination, the destination mode, the trigger mode and the mask.

Level-triggered pins are coalesced through a per-pin in-service flag (remote IRR), which the block owns. Once a level pin has been delivered, it is not delivered again until an end-of-interrupt (EOI) for its vector clears that flag. If the pin is still asserted when the EOI arrives, it is re-serviced at once. The block counts successive EOI re-assertions for each vector. When a vector keeps re-asserting, the block stops re-servicing it immediately and schedules a delayed re-service instead, so that an interrupt storm cannot monopolise the message port.

Line changes arrive as single events: a line index and a level. A separate pulse requests a full scan, for example after software has rewritten the table.

Top module: `irq_route_engine`

## Requirements
- R1: After reset, `msg_valid`, `pending` and `remote_irr` are all zero.
- R2: With `REMAP_LINE0` set, line 0 drives pin 2. Every other line `k` drives pin `k`. An event on a line index of `NUM_PINS` or above changes nothing.
- R3: An edge pin (trigger bit 15 = 0) with mask bit 16 = 0 reacts to a level-1 event by delivering exactly one message, after which its pending bit is clear. A level-0 event on an edge pin has no effect.
- R4: A level-1 event on a masked edge pin is dropped. Its pending bit stays 0, and no message follows even after the pin is unmasked and a scan is requested.
- R5: A level pin (trigger bit 15 = 1) reacts to a level-1 event by setting its pending bit. If its remote IRR is clear, it also delivers one message and sets remote IRR. A level-0 event clears its pending bit.
- R6: A level pin whose remote IRR is set produces no message, whether on a repeated level-1 event or on a requested scan.
- R7: A masked pin is skipped by the scan. A masked level pin keeps its pending bit.
- R8: The scan delivers pins in ascending index order, at most one message per cycle. While `msg_ready` is low, the offered message stays valid and unchanged.
- R9: Entry layout: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11, trigger in bit 15, mask in bit 16, destination in bits 63:48. The message address is 0xFEE00000 with the destination at bits 19:4 and the destination mode at bit 2. The message data holds the vector at bits 7:0, the delivery mode at bits 10:8 and the trigger at bit 15.
- R10: An EOI clears remote IRR only on a pin whose vector equals the EOI vector, which is level-triggered, and whose remote IRR is set. All other pins keep their remote IRR.
- R11: The remote IRR of a pin configured as edge-triggered reads 0.
- R12: When an EOI clears an unmasked pin that is still pending, the vector's counter increments, and while it stays below `STORM_LIMIT` the pin is re-delivered at once. When the cleared pin is masked or not pending, the counter returns to 0.
- R13: When the counter reaches `STORM_LIMIT`, it resets and no immediate re-delivery happens. A scan starts `DELAY_CYCLES` cycles later. An already scheduled delayed scan is left in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | Line event strobe |
| line_idx | input | IDX_W | Index of the line that changed |
| line_level | input | 1 | New level of that line |
| rte_table | input | NUM_PINS*64 | Redirection entries, pin p at bits p*64 +: 64 |
| svc_req | input | 1 | Request a full scan |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector being acknowledged |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with valid |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| pending | output | NUM_PINS | Pending bit per pin |
| remote_irr | output | NUM_PINS | In-service flag per pin |

## Verification
The pins are driven with edge and level events in the masked and unmasked configurations. Each pattern separates a correct delivery from a dropped one, and a coalesced delivery from a duplicated one. Two masked level pins are released together behind a stalled port, which shows both the ascending order and the hold of the offered message. EOI sequences on one vector cover a wrong vector, a non-pending pin that resets the counter, and repeated re-assertion up to the storm limit. Together they tell an immediate re-delivery from a delayed one, and show when the delayed one arrives.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int ENT_W   = 64;
   localparam int VEC_W   = 8;
   localparam int NUM_VEC = 1 << VEC_W;
   localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;

   typedef struct packed {
      logic [15:0]      dest;
      logic             dmode;
      logic [2:0]       dlv;
      logic             trig;
      logic             mask;
      logic [VEC_W-1:0] vec;
   } rte_t;

   function automatic rte_t rte_unpack(input logic [ENT_W-1:0] e);
      rte_t r;
      r.vec   = e[7:0];
      r.dlv   = e[10:8];
      r.dmode = e[11];
      r.trig  = e[15];
      r.mask  = e[16];
      r.dest  = e[63:48];
      return r;
   endfunction

   function automatic logic [31:0] rte_msg_addr(input rte_t r);
      return MSG_BASE | {12'h000, r.dest, 4'h0} | {29'd0, r.dmode, 2'b00};
   endfunction

   function automatic logic [31:0] rte_msg_data(input rte_t r);
      return {16'h0000, r.trig, 4'h0, r.dlv, r.vec};
   endfunction
endpackage

// File: rtl/irq_line_map.sv
module irq_line_map #(
   parameter int NUM_INPUTS  = 32,
   parameter int NUM_PINS    = 24,
   parameter bit REMAP_LINE0 = 1'b1,
   parameter int IDX_W       = 5
) (
   input  logic                ev_valid,
   input  logic [IDX_W-1:0]    ev_line,
   input  logic                ev_level,
   input  logic [NUM_PINS-1:0] trig,
   input  logic [NUM_PINS-1:0] mask,
   input  logic [NUM_PINS-1:0] rirr,
   output logic [NUM_PINS-1:0] set_pins,
   output logic [NUM_PINS-1:0] clr_pins,
   output logic                kick
);
   logic [IDX_W-1:0]    tgt;
   logic [NUM_PINS-1:0] kick_v;

   if (NUM_INPUTS < NUM_PINS) begin : g_bad_inputs
      $error("irq_line_map: NUM_INPUTS must cover NUM_PINS");
   end

   if (REMAP_LINE0) begin : g_remap
      assign tgt = (ev_line == '0) ? IDX_W'(2) : ev_line;
   end else begin : g_direct
      assign tgt = ev_line;
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic hit;
      assign hit         = ev_valid && (tgt == IDX_W'(p));
      assign set_pins[p] = hit && ev_level && (trig[p] || !mask[p]);
      assign clr_pins[p] = hit && !ev_level && trig[p];
      assign kick_v[p]   = hit && ev_level && (trig[p] ? !rirr[p] : !mask[p]);
   end

   assign kick = |kick_v;
endmodule

// File: rtl/irq_scan_unit.sv
module irq_scan_unit #(
   parameter int NUM_PINS = 24,
   parameter int PTR_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [NUM_PINS-1:0] irr,
   input  logic [NUM_PINS-1:0] rirr,
   input  logic [NUM_PINS-1:0] trig,
   input  logic [NUM_PINS-1:0] mask,
   input  logic                msg_ready,
   output logic                sel_valid,
   output logic [PTR_W-1:0]    sel_pin,
   output logic                fire
);
   logic                busy_q, again_q, hold_q;
   logic [PTR_W-1:0]    ptr_q, hold_pin_q;
   logic [NUM_PINS-1:0] need;
   logic                found;
   logic [PTR_W-1:0]    cand;

   assign need = irr & ~mask & (~trig | ~rirr);

   always_comb begin
      found = 1'b0;
      cand  = '0;
      for (int p = NUM_PINS - 1; p >= 0; p--) begin
         if (need[p] && (PTR_W'(p) >= ptr_q)) begin
            found = 1'b1;
            cand  = PTR_W'(p);
         end
      end
      if (hold_q) begin
         found = 1'b1;
         cand  = hold_pin_q;
      end
   end

   assign sel_valid = busy_q && found;
   assign sel_pin   = cand;
   assign fire      = sel_valid && msg_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         again_q    <= 1'b0;
         hold_q     <= 1'b0;
         ptr_q      <= '0;
         hold_pin_q <= '0;
      end else begin
         hold_q     <= sel_valid && !msg_ready;
         hold_pin_q <= cand;
         if (!busy_q) begin
            again_q <= 1'b0;
            if (start) begin
               busy_q <= 1'b1;
               ptr_q  <= '0;
            end
         end else if (found) begin
            if (fire)  ptr_q   <= cand + 1'b1;
            if (start) again_q <= 1'b1;
         end else if (again_q || start) begin
            ptr_q   <= '0;
            again_q <= 1'b0;
         end else begin
            busy_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/irq_eoi_unit.sv
module irq_eoi_unit
   import irq_route_pkg::*;
#(
   parameter int NUM_PINS     = 24,
   parameter int STORM_LIMIT  = 10000,
   parameter int DELAY_CYCLES = 1000000
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           eoi_valid,
   input  logic [VEC_W-1:0]               eoi_vec,
   input  logic [NUM_PINS-1:0][VEC_W-1:0] vecs,
   input  logic [NUM_PINS-1:0]            trig,
   input  logic [NUM_PINS-1:0]            mask,
   input  logic [NUM_PINS-1:0]            irr,
   input  logic [NUM_PINS-1:0]            rirr,
   output logic [NUM_PINS-1:0]            rirr_clr,
   output logic                           kick_now,
   output logic                           timer_fire
);
   localparam int CNT_W = $clog2(STORM_LIMIT + 1);
   localparam int DLY_W = $clog2(DELAY_CYCLES + 1);

   if (STORM_LIMIT < 1 || DELAY_CYCLES < 1) begin : g_bad_limits
      $error("irq_eoi_unit: STORM_LIMIT and DELAY_CYCLES must be positive");
   end

   logic [CNT_W-1:0] cnt_q [NUM_VEC];
   logic [CNT_W-1:0] cnt_nxt;
   logic             sched;
   logic             dly_act_q;
   logic [DLY_W-1:0] dly_q;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_match
      assign rirr_clr[p] = eoi_valid && (vecs[p] == eoi_vec) && trig[p] && rirr[p];
   end

   // Matching pins are visited in ascending order; the last one decides the count.
   always_comb begin
      cnt_nxt  = cnt_q[eoi_vec];
      kick_now = 1'b0;
      sched    = 1'b0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (rirr_clr[p]) begin
            if (!mask[p] && irr[p]) begin
               cnt_nxt = cnt_nxt + 1'b1;
               if (cnt_nxt >= CNT_W'(STORM_LIMIT)) begin
                  cnt_nxt = '0;
                  sched   = 1'b1;
               end else begin
                  kick_now = 1'b1;
               end
            end else begin
               cnt_nxt = '0;
            end
         end
      end
   end

   assign timer_fire = dly_act_q && (dly_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int v = 0; v < NUM_VEC; v++) cnt_q[v] <= '0;
         dly_act_q <= 1'b0;
         dly_q     <= '0;
      end else begin
         if (|rirr_clr) cnt_q[eoi_vec] <= cnt_nxt;
         if (dly_act_q) begin
            if (dly_q == '0) dly_act_q <= 1'b0;
            else             dly_q     <= dly_q - 1'b1;
         end else if (sched) begin
            dly_act_q <= 1'b1;
            dly_q     <= DLY_W'(DELAY_CYCLES - 1);
         end
      end
   end
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
   import irq_route_pkg::*;
#(
   parameter int NUM_PINS     = 24,
   parameter int NUM_INPUTS   = 32,
   parameter bit REMAP_LINE0  = 1'b1,
   parameter int STORM_LIMIT  = 10000,
   parameter int DELAY_CYCLES = 1000000,
   parameter int IDX_W        = $clog2(NUM_INPUTS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      line_valid,
   input  logic [IDX_W-1:0]          line_idx,
   input  logic                      line_level,
   input  logic [NUM_PINS*ENT_W-1:0] rte_table,
   input  logic                      svc_req,
   input  logic                      eoi_valid,
   input  logic [VEC_W-1:0]          eoi_vec,
   output logic                      msg_valid,
   input  logic                      msg_ready,
   output logic [31:0]               msg_addr,
   output logic [31:0]               msg_data,
   output logic [NUM_PINS-1:0]       pending,
   output logic [NUM_PINS-1:0]       remote_irr
);
   localparam int PTR_W = $clog2(NUM_PINS + 1);

   if (REMAP_LINE0 && (NUM_PINS < 3 || IDX_W < 2)) begin : g_bad_remap
      $error("irq_route_engine: line 0 remap needs at least three pins");
   end

   rte_t                           rte  [NUM_PINS];
   logic [NUM_PINS-1:0]            trig, mask;
   logic [NUM_PINS-1:0][VEC_W-1:0] vecs;
   logic [NUM_PINS-1:0]            irr_q, rirr_q, irr_d, rirr_d;
   logic [NUM_PINS-1:0]            set_pins, clr_pins, rirr_clr;
   logic                           line_kick, eoi_kick, timer_fire, start;
   logic                           sel_valid, fire;
   logic [PTR_W-1:0]               sel_pin;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_ent
      assign rte[p]  = rte_unpack(rte_table[p*ENT_W +: ENT_W]);
      assign trig[p] = rte[p].trig;
      assign mask[p] = rte[p].mask;
      assign vecs[p] = rte[p].vec;
   end

   irq_line_map #(
      .NUM_INPUTS (NUM_INPUTS),
      .NUM_PINS   (NUM_PINS),
      .REMAP_LINE0(REMAP_LINE0),
      .IDX_W      (IDX_W)
   ) u_map (
      .ev_valid(line_valid), .ev_line(line_idx), .ev_level(line_level),
      .trig(trig), .mask(mask), .rirr(rirr_q),
      .set_pins(set_pins), .clr_pins(clr_pins), .kick(line_kick)
   );

   irq_eoi_unit #(
      .NUM_PINS    (NUM_PINS),
      .STORM_LIMIT (STORM_LIMIT),
      .DELAY_CYCLES(DELAY_CYCLES)
   ) u_eoi (
      .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
      .vecs(vecs), .trig(trig), .mask(mask), .irr(irr_q), .rirr(rirr_q),
      .rirr_clr(rirr_clr), .kick_now(eoi_kick), .timer_fire(timer_fire)
   );

   assign start = svc_req | line_kick | eoi_kick | timer_fire;

   irq_scan_unit #(
      .NUM_PINS(NUM_PINS),
      .PTR_W   (PTR_W)
   ) u_scan (
      .clk(clk), .rst_n(rst_n), .start(start), .irr(irr_q), .rirr(rirr_q),
      .trig(trig), .mask(mask), .msg_ready(msg_ready),
      .sel_valid(sel_valid), .sel_pin(sel_pin), .fire(fire)
   );

   always_comb begin
      irr_d  = irr_q;
      rirr_d = rirr_q & ~rirr_clr;
      if (fire) begin
         if (trig[sel_pin]) rirr_d[sel_pin] = 1'b1;
         else               irr_d[sel_pin]  = 1'b0;
      end
      irr_d  = (irr_d & ~clr_pins) | set_pins;
      rirr_d = rirr_d & trig;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q  <= '0;
         rirr_q <= '0;
      end else begin
         irr_q  <= irr_d;
         rirr_q <= rirr_d;
      end
   end

   assign msg_valid  = sel_valid;
   assign msg_addr   = rte_msg_addr(rte[sel_pin]);
   assign msg_data   = rte_msg_data(rte[sel_pin]);
   assign pending    = irr_q;
   assign remote_irr = rirr_q;
endmodule

// File: rtl/irq_route_engine_chk.sv
module irq_route_engine_chk #(
   parameter int NUM_PINS = 24
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   eoi_valid,
   input logic [7:0]             eoi_vec,
   input logic [NUM_PINS*64-1:0] rte_table,
   input logic                   msg_valid,
   input logic                   msg_ready,
   input logic [31:0]            msg_addr,
   input logic [31:0]            msg_data,
   input logic [NUM_PINS-1:0]    remote_irr
);
   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      // R5: remote IRR is only raised by an accepted message
      assert_rirr_by_msg_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(remote_irr[p]) |-> $past(msg_valid && msg_ready));

      assert_edge_rirr_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !rte_table[p*64 + 15] |=> !remote_irr[p]);

      assert_eoi_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
         eoi_valid && (rte_table[p*64 +: 8] == eoi_vec) && rte_table[p*64 + 15]
         && remote_irr[p] |=> !remote_irr[p]);
   end
endmodule

bind irq_route_engine irq_route_engine_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
   .rte_table(rte_table), .msg_valid(msg_valid), .msg_ready(msg_ready),
   .msg_addr(msg_addr), .msg_data(msg_data), .remote_irr(remote_irr)
);

// File: tb/irq_route_engine_test.sv
module irq_route_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int NP    = 8;
   localparam int NI    = 12;
   localparam int IW    = $clog2(NI);
   localparam int LIMIT = 3;
   localparam int DLY   = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            line_valid = 1'b0;
   logic [IW-1:0]   line_idx = '0;
   logic            line_level = 1'b0;
   logic [NP*64-1:0] rte_table;
   logic            svc_req = 1'b0;
   logic            eoi_valid = 1'b0;
   logic [7:0]      eoi_vec = '0;
   logic            msg_valid, msg_ready = 1'b1;
   logic [31:0]     msg_addr, msg_data;
   logic [NP-1:0]   pending, remote_irr;

   logic [7:0]  b_vec   [NP];
   logic [2:0]  b_dlv   [NP];
   logic        b_dmode [NP];
   logic        b_trig  [NP];
   logic        b_mask  [NP];
   logic [15:0] b_dest  [NP];
   logic [63:0] got [$];
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int p = 0; p < NP; p++) begin
         rte_table[p*64 +: 64] = {b_dest[p], 31'd0, b_mask[p], b_trig[p],
                                  3'd0, b_dmode[p], b_dlv[p], b_vec[p]};
      end
   end

   irq_route_engine #(.NUM_PINS(NP), .NUM_INPUTS(NI), .REMAP_LINE0(1'b1),
                      .STORM_LIMIT(LIMIT), .DELAY_CYCLES(DLY)) uut (.*);

   always @(negedge clk) if (rst_n && msg_valid && msg_ready) got.push_back({msg_addr, msg_data});

   function automatic logic [63:0] exp_msg(int p);
      logic [31:0] a, d;
      a = 32'hFEE00000 | (32'(b_dest[p]) << 4) | (32'(b_dmode[p]) << 2);
      d = 32'(b_vec[p]) | (32'(b_dlv[p]) << 8) | (32'(b_trig[p]) << 15);
      return {a, d};
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic set_ent(int p, logic [7:0] v, logic [2:0] dl, logic dm,
                          logic tr, logic mk, logic [15:0] ds);
      b_vec[p] = v; b_dlv[p] = dl; b_dmode[p] = dm;
      b_trig[p] = tr; b_mask[p] = mk; b_dest[p] = ds;
   endtask

   task automatic line(int idx, logic lvl);
      line_valid = 1'b1; line_idx = IW'(idx); line_level = lvl;
      tick(1);
      line_valid = 1'b0;
   endtask

   task automatic eoi(logic [7:0] v);
      eoi_valid = 1'b1; eoi_vec = v;
      tick(1);
      eoi_valid = 1'b0;
   endtask

   task automatic svc();
      svc_req = 1'b1;
      tick(1);
      svc_req = 1'b0;
   endtask

   task automatic expect_msgs(string req, int n, int p0, int p1);
      check({req, " count"}, 64'(got.size()), 64'(n));
      if (n > 0 && got.size() > 0) check({req, " msg0"}, got[0], exp_msg(p0));
      if (n > 1 && got.size() > 1) check({req, " msg1"}, got[1], exp_msg(p1));
      got.delete();
   endtask

   initial begin
      for (int p = 0; p < NP; p++) set_ent(p, 8'(8'h20 + p), 3'd0, 1'b0, 1'b0, 1'b1, 16'(p));
      tick(3);
      check("R1 msg_valid", 64'(msg_valid), 64'd0);
      check("R1 pending", 64'(pending), 64'd0);
      check("R1 remote_irr", 64'(remote_irr), 64'd0);
      rst_n = 1'b1;
      tick(2);

      // R3 and R9: edge pin, full field check
      set_ent(3, 8'h5A, 3'd5, 1'b1, 1'b0, 1'b0, 16'hABCD);
      line(3, 1'b1); tick(6);
      expect_msgs("R3_R9 edge delivery", 1, 3, 0);
      check("R3 pending cleared", 64'(pending[3]), 64'd0);
      line(3, 1'b0); tick(6);
      expect_msgs("R3 deassert no effect", 0, 0, 0);

      // R4: masked edge dropped
      set_ent(1, 8'h31, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0001);
      line(1, 1'b1); tick(3);
      check("R4 pending", 64'(pending[1]), 64'd0);
      set_ent(1, 8'h31, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0001);
      svc(); tick(6);
      expect_msgs("R4 masked edge", 0, 0, 0);

      // R2: line 0 to pin 2, line 2 to pin 2, high line ignored
      set_ent(0, 8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000);
      set_ent(2, 8'h42, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0002);
      line(0, 1'b1); tick(6);
      expect_msgs("R2 line0 remap", 1, 2, 0);
      line(2, 1'b1); tick(6);
      expect_msgs("R2 line2 direct", 1, 2, 0);
      line(10, 1'b1); tick(6);
      expect_msgs("R2 high line", 0, 0, 0);
      check("R2 pending untouched", 64'(pending), 64'd0);

      // R5, R6: level pin
      set_ent(5, 8'h55, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0005);
      line(5, 1'b1); tick(6);
      expect_msgs("R5 level delivery", 1, 5, 0);
      check("R5 remote set", 64'(remote_irr[5]), 64'd1);
      check("R5 pending set", 64'(pending[5]), 64'd1);
      line(5, 1'b1); svc(); tick(6);
      expect_msgs("R6 coalesced", 0, 0, 0);
      line(5, 1'b0); tick(1);
      check("R5 pending cleared", 64'(pending[5]), 64'd0);

      // R10: wrong vector keeps remote; right vector clears without redelivery
      eoi(8'h77); tick(1);
      check("R10 wrong vector", 64'(remote_irr[5]), 64'd1);
      eoi(8'h55); tick(6);
      check("R10 cleared", 64'(remote_irr[5]), 64'd0);
      expect_msgs("R12 not pending no redelivery", 0, 0, 0);

      // R7, R8: masked level pins 1 and 6, released behind a stalled port
      set_ent(1, 8'h61, 3'd2, 1'b0, 1'b1, 1'b1, 16'h0101);
      set_ent(6, 8'h66, 3'd3, 1'b1, 1'b1, 1'b1, 16'h0606);
      line(6, 1'b1); line(1, 1'b1); tick(6);
      expect_msgs("R7 masked skipped", 0, 0, 0);
      check("R7 pending kept", 64'(pending & 8'h42), 64'h42);
      msg_ready = 1'b0;
      set_ent(1, 8'h61, 3'd2, 1'b0, 1'b1, 1'b0, 16'h0101);
      set_ent(6, 8'h66, 3'd3, 1'b1, 1'b1, 1'b0, 16'h0606);
      svc(); tick(4);
      check("R8 stall valid", 64'(msg_valid), 64'd1);
      check("R8 stall holds lowest", {msg_addr, msg_data}, exp_msg(1));
      msg_ready = 1'b1;
      tick(6);
      expect_msgs("R8 ascending order", 2, 1, 6);
      line(1, 1'b0); line(6, 1'b0);
      eoi(8'h61); eoi(8'h66);

      // R12, R13: storm counting on pin 4
      set_ent(4, 8'h60, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0404);
      line(4, 1'b1); tick(6);
      expect_msgs("R5 pin4 first", 1, 4, 0);
      eoi(8'h60); tick(6);
      expect_msgs("R12 redeliver cnt1", 1, 4, 0);
      eoi(8'h60); tick(6);
      expect_msgs("R12 redeliver cnt2", 1, 4, 0);
      line(4, 1'b0);
      eoi(8'h60); tick(6);
      expect_msgs("R12 reset count", 0, 0, 0);
      line(4, 1'b1); tick(6);
      expect_msgs("R5 pin4 reassert", 1, 4, 0);
      eoi(8'h60); tick(6);
      expect_msgs("R12 after reset cnt1", 1, 4, 0);
      eoi(8'h60); tick(6);
      expect_msgs("R12 after reset cnt2", 1, 4, 0);
      eoi(8'h60); tick(10);
      expect_msgs("R13 no immediate", 0, 0, 0);
      tick(15);
      expect_msgs("R13 delayed redelivery", 1, 4, 0);

      // R11: switching to edge drops remote IRR
      check("R11 before", 64'(remote_irr[4]), 64'd1);
      set_ent(4, 8'h60, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0404);
      tick(2);
      check("R11 edge forces zero", 64'(remote_irr[4]), 64'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule